// File: doc/BRIEF.md
# Register Window Controller

This block keeps the bookkeeping for a windowed integer register file. It holds the current window pointer and two occupancy counters: the number of windows that can still be allocated without spilling, and the number that can be released without filling. Three request kinds arrive on a valid/opcode pair: allocate a window, release a window, and flush all windows. Each request either moves the pointer and shifts the counters, or raises a typed trap so that a handler can spill or fill a window, or clean one. The pointer moves on some trapping requests too, so the handler runs in the window it has to repair.

The clean-window limit, the "other windows" count and the six-bit trap-type selector come from elsewhere and are block inputs. All pointer arithmetic wraps modulo the window count `NWIN`. Results are registered on the clock edge that accepts a request. The outcome is shown for one cycle by a small response state machine with three states. `RS_QUIET` means nothing was accepted. `RS_DONE` means a request completed without a trap. `RS_TRAP` means a trap was raised. Every cycle the machine moves to one of these three states: `RS_QUIET` when no request is taken or the opcode is the unused one, `RS_TRAP` when the request traps, and `RS_DONE` otherwise.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the pointer is 0, the allocatable count is NWIN-2, the releasable count is 0, and both `done_o` and `trap_o` are low.
- R2: An allocate (op 2'b00) with a nonzero allocatable count and `cleanwin_i` different from the releasable count advances the pointer by 1. It decrements the allocatable count, increments the releasable count and pulses `done_o`.
- R3: An allocate with the allocatable count at 0 raises a spill trap (kind 1 normal, 2 other), advances the pointer by 2 and leaves both counters unchanged. This check takes priority over the clean check of R4.
- R4: An allocate with a nonzero allocatable count and `cleanwin_i` equal to the releasable count raises a clean trap (kind 5, vector 0). It advances the pointer by 1 and leaves both counters unchanged.
- R5: A release (op 2'b01) always moves the pointer back by 1, whether or not it traps.
- R6: A release with the releasable count at 0 raises a fill trap (kind 3 normal, 4 other) with the counters unchanged. Otherwise it increments the allocatable count, decrements the releasable count and pulses `done_o`. The two counters always sum to NWIN-2.
- R7: A flush (op 2'b10) raises a spill trap when the allocatable count differs from NWIN-2, and otherwise pulses `done_o`. In both cases the pointer and the counters are unchanged.
- R8: When `otherwin_i` is nonzero, spill and fill traps take the "other" kind and their vector is `wstate_i[5:3]`. Otherwise they take the "normal" kind and the vector is `wstate_i[2:0]`.
- R9: Op 2'b11, or `req_valid` low, changes no state and produces no pulse.
- R10: `trap_o` and `done_o` are high only in the cycle after the accepting edge. `trap_kind_o` is nonzero exactly while `trap_o` is high.
- R11: The pointer wraps: NWIN-1 plus 1 gives 0, NWIN-2 plus 2 gives 0, and 0 minus 1 gives NWIN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 allocate, 01 release, 10 flush, 11 unused |
| cleanwin_i | input | CW | Clean-window limit |
| otherwin_i | input | CW | Windows owned by another context |
| wstate_i | input | 6 | Trap-type selector, [5:3] other, [2:0] normal |
| cwp_o | output | PW | Current window pointer |
| cansave_o | output | CW | Allocatable window count |
| canrestore_o | output | CW | Releasable window count |
| done_o | output | 1 | One-cycle pulse: request completed |
| trap_o | output | 1 | One-cycle pulse: trap raised |
| trap_kind_o | output | 3 | 0 none, 1 spill normal, 2 spill other, 3 fill normal, 4 fill other, 5 clean |
| trap_vec_o | output | 3 | Selected trap-type field |

## Verification
A corrupted pointer or counter shows up on `cwp_o`, `cansave_o` and `canrestore_o` one cycle after the faulty request. It also changes the trap decision of a later request, so an allocate that should spill completes instead, or the reverse. The tests walk the counters to both ends so that a wrong counter update shows up as a wrong pulse choice within a few requests. Wrap errors appear the first time the pointer crosses 0 in either direction.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        OP_SAVE    = 2'b00,
        OP_RESTORE = 2'b01,
        OP_FLUSH   = 2'b10,
        OP_NONE    = 2'b11
    } win_op_e;

    typedef enum logic [2:0] {
        TK_NONE       = 3'd0,
        TK_SPILL_NORM = 3'd1,
        TK_SPILL_OTH  = 3'd2,
        TK_FILL_NORM  = 3'd3,
        TK_FILL_OTH   = 3'd4,
        TK_CLEAN      = 3'd5
    } trap_kind_e;

    typedef enum logic [1:0] {
        MV_HOLD  = 2'd0,
        MV_FWD1  = 2'd1,
        MV_FWD2  = 2'd2,
        MV_BACK1 = 2'd3
    } ptr_move_e;

    typedef enum logic [1:0] {
        RS_QUIET = 2'd0,
        RS_DONE  = 2'd1,
        RS_TRAP  = 2'd2
    } resp_state_e;

endpackage

// File: rtl/regwin_ptr_step.sv
module regwin_ptr_step
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int PW   = $clog2(NWIN)
) (
    input  logic [PW-1:0] cur,
    input  ptr_move_e     move,
    output logic [PW-1:0] nxt
);
    localparam bool_pow2 = (NWIN == (1 << PW));

    generate
        if (bool_pow2) begin : g_pow2
            // Natural wrap of a PW-bit adder is the modulo.
            always_comb begin
                unique case (move)
                    MV_FWD1:  nxt = cur + PW'(1);
                    MV_FWD2:  nxt = cur + PW'(2);
                    MV_BACK1: nxt = cur - PW'(1);
                    default:  nxt = cur;
                endcase
            end
        end else begin : g_cmp
            localparam logic [PW:0] LIM = (PW+1)'(NWIN);
            logic [PW:0] ofs;
            logic [PW:0] sum;
            always_comb begin
                unique case (move)
                    MV_FWD1:  ofs = (PW+1)'(1);
                    MV_FWD2:  ofs = (PW+1)'(2);
                    MV_BACK1: ofs = LIM - (PW+1)'(1);
                    default:  ofs = '0;
                endcase
                // cur < NWIN and ofs < NWIN, so one correction suffices.
                sum = {1'b0, cur} + ofs;
                if (sum >= LIM) sum = sum - LIM;
                nxt = sum[PW-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/regwin_decide.sv
module regwin_decide
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input  win_op_e        op,
    input  logic [CW-1:0]  cansave,
    input  logic [CW-1:0]  canrestore,
    input  logic [CW-1:0]  cleanwin,
    input  logic [CW-1:0]  otherwin,
    input  logic [5:0]     wstate,
    output logic           act,
    output logic           is_trap,
    output ptr_move_e      move,
    output trap_kind_e     kind,
    output logic [2:0]     vec,
    output logic [CW-1:0]  cansave_nxt,
    output logic [CW-1:0]  canrestore_nxt
);
    localparam logic [CW-1:0] FULL = CW'(NWIN - 2);

    logic       use_other;
    logic [2:0] sel_vec;
    trap_kind_e spill_k;
    trap_kind_e fill_k;

    always_comb begin
        use_other = |otherwin;
        sel_vec   = use_other ? wstate[5:3] : wstate[2:0];
        spill_k   = use_other ? TK_SPILL_OTH : TK_SPILL_NORM;
        fill_k    = use_other ? TK_FILL_OTH  : TK_FILL_NORM;
    end

    always_comb begin
        act            = 1'b1;
        is_trap        = 1'b0;
        move           = MV_HOLD;
        kind           = TK_NONE;
        vec            = 3'd0;
        cansave_nxt    = cansave;
        canrestore_nxt = canrestore;
        unique case (op)
            OP_SAVE: begin
                if (cansave == '0) begin
                    is_trap = 1'b1;
                    move    = MV_FWD2;
                    kind    = spill_k;
                    vec     = sel_vec;
                end else if (cleanwin == canrestore) begin
                    is_trap = 1'b1;
                    move    = MV_FWD1;
                    kind    = TK_CLEAN;
                end else begin
                    move           = MV_FWD1;
                    cansave_nxt    = cansave - CW'(1);
                    canrestore_nxt = canrestore + CW'(1);
                end
            end
            OP_RESTORE: begin
                move = MV_BACK1;
                if (canrestore == '0) begin
                    is_trap = 1'b1;
                    kind    = fill_k;
                    vec     = sel_vec;
                end else begin
                    cansave_nxt    = cansave + CW'(1);
                    canrestore_nxt = canrestore - CW'(1);
                end
            end
            OP_FLUSH: begin
                if (cansave != FULL) begin
                    is_trap = 1'b1;
                    kind    = spill_k;
                    vec     = sel_vec;
                end
            end
            default: begin
                act = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int PW   = $clog2(NWIN),
    parameter int CW   = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [CW-1:0] cleanwin_i,
    input  logic [CW-1:0] otherwin_i,
    input  logic [5:0]    wstate_i,
    output logic [PW-1:0] cwp_o,
    output logic [CW-1:0] cansave_o,
    output logic [CW-1:0] canrestore_o,
    output logic          done_o,
    output logic          trap_o,
    output logic [2:0]    trap_kind_o,
    output logic [2:0]    trap_vec_o
);
    localparam logic [CW-1:0] CS_RESET = CW'(NWIN - 2);

    logic [PW-1:0] cwp_q;
    logic [CW-1:0] cs_q, cr_q;
    trap_kind_e    kind_q;
    logic [2:0]    vec_q;
    resp_state_e   state_q, state_d;

    logic          dec_act, dec_trap;
    ptr_move_e     dec_move;
    trap_kind_e    dec_kind;
    logic [2:0]    dec_vec;
    logic [CW-1:0] cs_nxt, cr_nxt;
    logic [PW-1:0] cwp_nxt;
    logic          take;

    regwin_decide #(.NWIN(NWIN), .CW(CW)) u_decide (
        .op             (win_op_e'(req_op)),
        .cansave        (cs_q),
        .canrestore     (cr_q),
        .cleanwin       (cleanwin_i),
        .otherwin       (otherwin_i),
        .wstate         (wstate_i),
        .act            (dec_act),
        .is_trap        (dec_trap),
        .move           (dec_move),
        .kind           (dec_kind),
        .vec            (dec_vec),
        .cansave_nxt    (cs_nxt),
        .canrestore_nxt (cr_nxt)
    );

    regwin_ptr_step #(.NWIN(NWIN), .PW(PW)) u_step (
        .cur  (cwp_q),
        .move (dec_move),
        .nxt  (cwp_nxt)
    );

    assign take = req_valid && dec_act;

    // Next response state.
    always_comb begin
        if (!take)         state_d = RS_QUIET;
        else if (dec_trap) state_d = RS_TRAP;
        else               state_d = RS_DONE;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_QUIET;
        else        state_q <= state_d;
    end

    // Window state and trap payload.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cwp_q  <= '0;
            cs_q   <= CS_RESET;
            cr_q   <= '0;
            kind_q <= TK_NONE;
            vec_q  <= 3'd0;
        end else if (take) begin
            cwp_q  <= cwp_nxt;
            cs_q   <= cs_nxt;
            cr_q   <= cr_nxt;
            kind_q <= dec_kind;
            vec_q  <= dec_vec;
        end
    end

    // Outputs from state.
    always_comb begin
        cwp_o        = cwp_q;
        cansave_o    = cs_q;
        canrestore_o = cr_q;
        done_o       = 1'b0;
        trap_o       = 1'b0;
        trap_kind_o  = 3'd0;
        trap_vec_o   = 3'd0;
        unique case (state_q)
            RS_DONE: done_o = 1'b1;
            RS_TRAP: begin
                trap_o      = 1'b1;
                trap_kind_o = kind_q;
                trap_vec_o  = vec_q;
            end
            default: ;
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !trap_o && !done_o && $stable(cwp_q) && $stable(cs_q)); // R9
    AST_TRAP_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> trap_kind_o != 3'd0); // R10
    AST_SAVE_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == OP_SAVE && cs_q == '0
        |=> trap_o && int'(cwp_q) == (int'($past(cwp_q)) + 2) % NWIN); // R3
    AST_RESTORE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == OP_RESTORE
        |=> int'(cwp_q) == (int'($past(cwp_q)) + NWIN - 1) % NWIN); // R5
    AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cs_q) + int'(cr_q) == NWIN - 2); // R6
    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == OP_FLUSH |=> $stable(cwp_q) && $stable(cs_q) && $stable(cr_q)); // R7
endmodule

// File: tb/tb_regwin_ctrl.sv
module tb_regwin_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int PW = 3;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [CW-1:0] cleanwin_i = '0;
    logic [CW-1:0] otherwin_i = '0;
    logic [5:0]    wstate_i = 6'b101_011;
    logic [PW-1:0] cwp_o;
    logic [CW-1:0] cansave_o, canrestore_o;
    logic          done_o, trap_o;
    logic [2:0]    trap_kind_o, trap_vec_o;

    int total = 0;
    int bad = 0;
    int m_cwp, m_cs, m_cr;
    int e_trap, e_done, e_kind, e_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    regwin_ctrl #(.NWIN(NW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .cleanwin_i(cleanwin_i), .otherwin_i(otherwin_i), .wstate_i(wstate_i),
        .cwp_o(cwp_o), .cansave_o(cansave_o), .canrestore_o(canrestore_o),
        .done_o(done_o), .trap_o(trap_o), .trap_kind_o(trap_kind_o),
        .trap_vec_o(trap_vec_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected outcome from the requirements.
    task automatic model(input logic [1:0] op);
        bit oth;
        int v;
        oth = (otherwin_i != 0);
        v = oth ? int'(wstate_i[5:3]) : int'(wstate_i[2:0]);
        e_trap = 0; e_done = 0; e_kind = 0; e_vec = 0;
        case (op)
            2'b00: begin
                if (m_cs == 0) begin
                    e_trap = 1; e_kind = oth ? 2 : 1; e_vec = v;
                    m_cwp = (m_cwp + 2) % NW;
                end else if (int'(cleanwin_i) == m_cr) begin
                    e_trap = 1; e_kind = 5;
                    m_cwp = (m_cwp + 1) % NW;
                end else begin
                    e_done = 1; m_cwp = (m_cwp + 1) % NW; m_cs--; m_cr++;
                end
            end
            2'b01: begin
                m_cwp = (m_cwp + NW - 1) % NW;
                if (m_cr == 0) begin
                    e_trap = 1; e_kind = oth ? 4 : 3; e_vec = v;
                end else begin
                    e_done = 1; m_cs++; m_cr--;
                end
            end
            2'b10: begin
                if (m_cs != NW - 2) begin
                    e_trap = 1; e_kind = oth ? 2 : 1; e_vec = v;
                end else e_done = 1;
            end
            default: ;
        endcase
    endtask

    task automatic issue(input string tag, input logic [1:0] op, input bit valid);
        if (valid) model(op);
        else begin e_trap = 0; e_done = 0; e_kind = 0; e_vec = 0; end
        @(negedge clk);
        req_valid = valid;
        req_op = op;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, "cwp", int'(cwp_o), m_cwp);
        check(tag, "cansave", int'(cansave_o), m_cs);
        check(tag, "canrestore", int'(canrestore_o), m_cr);
        check(tag, "trap", int'(trap_o), e_trap);
        check(tag, "done", int'(done_o), e_done);
        check(tag, "kind", int'(trap_kind_o), e_kind);
        check(tag, "vec", int'(trap_vec_o), e_vec);
    endtask

    task automatic t_reset();
        m_cwp = 0; m_cs = NW - 2; m_cr = 0;
        check("R1", "cwp", int'(cwp_o), 0);
        check("R1", "cansave", int'(cansave_o), NW - 2);
        check("R1", "canrestore", int'(canrestore_o), 0);
        check("R1", "pulses", int'(trap_o) + int'(done_o), 0);
    endtask

    task automatic t_fill_and_wrap();
        otherwin_i = 0; cleanwin_i = 3'd7;
        issue("R6_fill_R11_wrap_back", 2'b01, 1'b1);   // 0 -> 7, fill normal
        check("R5", "cwp after trap", int'(cwp_o), NW - 1);
        issue("R2_R11_wrap_fwd", 2'b00, 1'b0 | 1'b1);  // 7 -> 0 success
        otherwin_i = 3'd2;
        issue("R6_release", 2'b01, 1'b1);
        issue("R8_fill_other", 2'b01, 1'b1);
        check("R8", "other vec", int'(trap_vec_o), 5);
    endtask

    task automatic t_clean();
        otherwin_i = 0; cleanwin_i = 3'd0;
        issue("R4_clean", 2'b00, 1'b1);
        @(negedge clk);
        check("R10", "trap pulse width", int'(trap_o), 0);
        check("R10", "kind after pulse", int'(trap_kind_o), 0);
    endtask

    task automatic t_spill();
        cleanwin_i = 3'd7;
        for (int i = 0; i < NW - 2; i++) issue("R2_save_run", 2'b00, 1'b1);
        check("R2", "cansave drained", int'(cansave_o), 0);
        cleanwin_i = 3'(NW - 2);
        issue("R3_spill_priority", 2'b00, 1'b1);
        otherwin_i = 3'd1;
        issue("R3_R8_spill_other", 2'b00, 1'b1);
        check("R8", "spill other kind", int'(trap_kind_o), 2);
    endtask

    task automatic t_flush();
        otherwin_i = 0;
        issue("R7_flush_spill", 2'b10, 1'b1);
        for (int i = 0; i < NW - 2; i++) issue("R6_release_run", 2'b01, 1'b1);
        issue("R7_flush_done", 2'b10, 1'b1);
        check("R7", "flush done pulse", int'(done_o), 1);
    endtask

    task automatic t_ignore();
        issue("R9_unused_op", 2'b11, 1'b1);
        issue("R9_valid_low", 2'b00, 1'b0);
        issue("R9_valid_low_restore", 2'b01, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_wrap();
        t_clean();
        t_spill();
        t_flush();
        t_ignore();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule